// File: doc/BRIEF.md
# Link Activity Meter

This block measures activity on a PCIe link over a window that software opens and closes by hand. Software writes one control word that carries a report code, a window mode and an enable bit. While the window is open, a single 64-bit accumulator gathers one kind of activity: every clock cycle, cycles spent in one link power or training state, or transmitted or received data payload of one TLP class, counted in 16-byte units.

The link training logic supplies one flag per state, valid each cycle. The transaction datapath supplies per-cycle byte counts for each direction and each of two TLP classes. Opening a new window clears the result automatically, so software never clears it. The 64-bit result is read over a 32-bit register bus. Reading the upper word captures the lower word at the same moment, so a high-then-low read pair always returns one consistent value. There is no overflow interrupt. Only one report code is active at a time.

Top module: `link_activity_meter`

## Requirements
- R1: After reset, the control register and both result words read as zero.
- R2: Report code 0x00 adds one to the result for every clock cycle counted in the window.
- R3: Report codes 0x01 to 0x09 add one for each counted cycle in which `state_flags` bit (code minus 1) is high. Bit 0 is TX L0s, bit 1 RX L0s, bit 2 L0, bit 3 L1, bit 4 L1.1, bit 5 L1.2, bit 6 configuration/recovery, bit 7 L0s in both directions, and bit 8 L1 aux.
- R4: Report code 0x20 counts class-0 TX payload (`pl_tx_bytes[7:0]`), 0x21 class-0 RX (`pl_rx_bytes[7:0]`), 0x22 class-1 TX (`pl_tx_bytes[15:8]`) and 0x23 class-1 RX (`pl_rx_bytes[15:8]`). The result is the window's total byte count divided by 16, rounded down. A remainder carries from cycle to cycle within a window and is dropped when the next window opens.
- R5: When the duration field is 0 (manual), the write that sets enable starts a window on the following clock edge. Inputs are counted from the edge after that one, up to and including the edge that captures the write clearing enable. A gap of W idle cycles between the two writes therefore counts W cycles of input.
- R6: The start of a window clears the result. After a window closes, the result holds its value.
- R7: While the duration field is not 0, setting enable starts no window, and the result keeps its previous value.
- R8: A report code outside 0x00 to 0x09 and 0x20 to 0x23 leaves the result at zero for the whole window.
- R9: Writing a new report code while the window is open has no effect until enable next rises.
- R10: Reading the high word (offset 0x8, result bits 63:32) captures result bits 31:0. The next read of the low word (offset 0x4) returns that captured value. A low read with no capture pending returns the live bits 31:0.
- R11: The control register at offset 0x0 holds enable at bit 0, the duration field at bits 11:8 and the report code at bits 31:24. Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects occur at the clock edge) |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| state_flags | input | 9 | Per-cycle link state indications, one bit per state code |
| pl_tx_bytes | input | 16 | Per-cycle TX payload bytes, 8 bits per TLP class |
| pl_rx_bytes | input | 16 | Per-cycle RX payload bytes, 8 bits per TLP class |

## Verification
The assertions check, on every cycle, the rules that are local in time. The result is zero right after a window opens. It steps by exactly one per cycle under report code 0x00. It stays frozen while no window is open. It stays at zero under an unlisted code. A low read that directly follows a high read returns the value captured at the high read. Other behaviours only show up in the bench's scenarios: the exact edges that bound a window, the payload arithmetic with carried remainders, the code change in mid-window that does not take effect, the blocked start in a non-manual mode, and the control readback.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int NSTATE      = 9;
    localparam int CODEW       = 8;
    localparam int DURW        = 4;
    localparam int ADDRW       = 4;

    localparam logic [ADDRW-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDRW-1:0] OFS_LO   = 4'h4;
    localparam logic [ADDRW-1:0] OFS_HI   = 4'h8;

    localparam logic [CODEW-1:0] CODE_CYCLES  = 8'h00;
    localparam logic [CODEW-1:0] CODE_PAYBASE = 8'h20;
    localparam logic [DURW-1:0]  DUR_MANUAL   = 4'h0;

    localparam int POS_EN   = 0;
    localparam int POS_DUR  = 8;
    localparam int POS_CODE = 24;

    typedef struct packed {
        logic [CODEW-1:0] report;
        logic [DURW-1:0]  dur;
        logic             en;
    } lam_ctrl_t;

    typedef struct packed {
        logic cyc_hit;
        logic pay_sel;
        logic code_ok;
    } lam_pick_t;

    function automatic logic [31:0] ctrl_to_word(input lam_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[POS_EN] = c.en;
        w[POS_DUR +: DURW] = c.dur;
        w[POS_CODE +: CODEW] = c.report;
        return w;
    endfunction

    function automatic lam_ctrl_t word_to_ctrl(input logic [31:0] w);
        lam_ctrl_t c;
        c.en     = w[POS_EN];
        c.dur    = w[POS_DUR +: DURW];
        c.report = w[POS_CODE +: CODEW];
        return c;
    endfunction

endpackage

// File: rtl/lam_regif.sv
module lam_regif
    import lam_pkg::*;
#(
    parameter int BUSW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDRW-1:0]     reg_addr,
    input  logic [BUSW-1:0]      reg_wdata,
    output logic [BUSW-1:0]      reg_rdata,
    input  logic [2*BUSW-1:0]    acc,
    output lam_ctrl_t            ctrl_o,
    output logic                 run_o
);
    localparam int ACCW = 2 * BUSW;

    lam_ctrl_t         ctrl_q;
    logic [BUSW-1:0]   snap_q;
    logic              snap_vld_q;

    wire rd_hi = reg_rd && (reg_addr == OFS_HI);
    wire rd_lo = reg_rd && (reg_addr == OFS_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_CTRL)
                ctrl_q <= word_to_ctrl(reg_wdata);
            if (rd_hi) begin
                snap_q     <= acc[BUSW-1:0];
                snap_vld_q <= 1'b1;
            end else if (rd_lo) begin
                snap_vld_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata = ctrl_to_word(ctrl_q);
            OFS_LO:   reg_rdata = snap_vld_q ? snap_q : acc[BUSW-1:0];
            OFS_HI:   reg_rdata = acc[ACCW-1:BUSW];
            default:  reg_rdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign run_o  = ctrl_q.en && (ctrl_q.dur == DUR_MANUAL);

    // R10: a low read right after a high read returns the value captured then
    p_snap_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_HI) ##1 (reg_rd && reg_addr == OFS_LO)
        |-> reg_rdata == $past(acc[BUSW-1:0]));

endmodule

// File: rtl/lam_src_sel.sv
module lam_src_sel
    import lam_pkg::*;
#(
    parameter int NCLS  = 2,
    parameter int BYTEW = 8
) (
    input  logic [CODEW-1:0]        code,
    input  logic [NSTATE-1:0]       state_flags,
    input  logic [NCLS*BYTEW-1:0]   tx_bytes,
    input  logic [NCLS*BYTEW-1:0]   rx_bytes,
    output lam_pick_t               pick,
    output logic [BYTEW-1:0]        pay_bytes
);
    localparam int NPAY = 2 * NCLS;

    logic [NPAY-1:0]  pay_hit;
    logic [BYTEW-1:0] pay_src [NPAY];

    genvar g;
    generate
        for (g = 0; g < NCLS; g++) begin : g_cls
            assign pay_hit[2*g]     = (code == CODE_PAYBASE + CODEW'(2*g));
            assign pay_hit[2*g + 1] = (code == CODE_PAYBASE + CODEW'(2*g + 1));
            assign pay_src[2*g]     = tx_bytes[g*BYTEW +: BYTEW];
            assign pay_src[2*g + 1] = rx_bytes[g*BYTEW +: BYTEW];
        end
    endgenerate

    always_comb begin
        pick      = '0;
        pay_bytes = '0;
        if (code == CODE_CYCLES) begin
            pick.cyc_hit = 1'b1;
            pick.code_ok = 1'b1;
        end
        for (int i = 0; i < NSTATE; i++) begin
            if (code == CODEW'(i + 1)) begin
                pick.cyc_hit = state_flags[i];
                pick.code_ok = 1'b1;
            end
        end
        for (int j = 0; j < NPAY; j++) begin
            if (pay_hit[j]) begin
                pick.pay_sel = 1'b1;
                pick.code_ok = 1'b1;
                pay_bytes    = pay_src[j];
            end
        end
    end

endmodule

// File: rtl/lam_accum.sv
module lam_accum
    import lam_pkg::*;
#(
    parameter int ACCW  = 64,
    parameter int BYTEW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CODEW-1:0]   code_in,
    input  lam_pick_t          pick,
    input  logic [BYTEW-1:0]   pay_bytes,
    output logic [CODEW-1:0]   code_q,
    output logic [ACCW-1:0]    acc_q
);
    localparam int UNITSH = 4;
    localparam int SUMW   = BYTEW + 1;

    logic              run_d;
    logic [UNITSH-1:0] res_q;
    logic [SUMW-1:0]   sum;
    logic [ACCW-1:0]   units;
    logic              start;

    assign start = run && !run_d;
    assign sum   = SUMW'(pay_bytes) + SUMW'(res_q);
    assign units = ACCW'(sum[SUMW-1:UNITSH]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_d  <= 1'b0;
            res_q  <= '0;
            acc_q  <= '0;
            code_q <= CODE_CYCLES;
        end else begin
            run_d <= run;
            if (start) begin
                acc_q  <= '0;
                res_q  <= '0;
                code_q <= code_in;
            end else if (run) begin
                if (pick.pay_sel) begin
                    acc_q <= acc_q + units;
                    res_q <= sum[UNITSH-1:0];
                end else begin
                    acc_q <= acc_q + ACCW'(pick.cyc_hit);
                end
            end
        end
    end

    // R6: a window start leaves the result at zero
    p_start_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (run && !run_d) |=> acc_q == '0);

    // R6: the result is frozen while no window is open
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> acc_q == $past(acc_q));

    // R2: cycle code steps by one per counted cycle
    p_cycle_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && run_d && code_q == CODE_CYCLES) |=> acc_q == $past(acc_q) + 1);

    // R8: an unlisted code keeps the result at zero
    p_unknown_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (run_d && !pick.code_ok) |-> acc_q == '0);

    // R9: the latched code does not move within an open window
    p_code_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (run && run_d) |=> $stable(code_q));

endmodule

// File: rtl/link_activity_meter.sv
module link_activity_meter
    import lam_pkg::*;
#(
    parameter int BUSW  = 32,
    parameter int NCLS  = 2,
    parameter int BYTEW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [3:0]               reg_addr,
    input  logic [BUSW-1:0]          reg_wdata,
    output logic [BUSW-1:0]          reg_rdata,
    input  logic [8:0]               state_flags,
    input  logic [NCLS*BYTEW-1:0]    pl_tx_bytes,
    input  logic [NCLS*BYTEW-1:0]    pl_rx_bytes
);
    localparam int ACCW = 2 * BUSW;

    lam_ctrl_t        ctrl;
    logic             run;
    logic [CODEW-1:0] code_q;
    logic [ACCW-1:0]  acc;
    lam_pick_t        pick;
    logic [BYTEW-1:0] pay_bytes;

    lam_regif #(.BUSW(BUSW)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc       (acc),
        .ctrl_o    (ctrl),
        .run_o     (run)
    );

    lam_src_sel #(.NCLS(NCLS), .BYTEW(BYTEW)) u_sel (
        .code        (code_q),
        .state_flags (state_flags),
        .tx_bytes    (pl_tx_bytes),
        .rx_bytes    (pl_rx_bytes),
        .pick        (pick),
        .pay_bytes   (pay_bytes)
    );

    lam_accum #(.ACCW(ACCW), .BYTEW(BYTEW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .code_in   (ctrl.report),
        .pick      (pick),
        .pay_bytes (pay_bytes),
        .code_q    (code_q),
        .acc_q     (acc)
    );

endmodule

// File: tb/link_activity_meter_tb.sv
module link_activity_meter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic [7:0]  code;
        logic [8:0]  flags;
        logic [15:0] txb;
        logic [15:0] rxb;
        logic [7:0]  win;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{8'h00, 9'h000, 16'h0000, 16'h0000, 8'd10, 32'd10},
        '{8'h01, 9'h001, 16'h0000, 16'h0000, 8'd7,  32'd7},
        '{8'h03, 9'h1F7, 16'h0000, 16'h0000, 8'd5,  32'd5},
        '{8'h05, 9'h1EF, 16'h0000, 16'h0000, 8'd6,  32'd0},
        '{8'h09, 9'h100, 16'h0000, 16'h0000, 8'd4,  32'd4},
        '{8'h07, 9'h040, 16'h0000, 16'h0000, 8'd3,  32'd3},
        '{8'h20, 9'h1FF, 16'h0010, 16'h0000, 8'd8,  32'd8},
        '{8'h21, 9'h000, 16'h0000, 16'h0028, 8'd5,  32'd12},
        '{8'h22, 9'h000, 16'h0764, 16'h0000, 8'd9,  32'd3},
        '{8'h22, 9'h000, 16'h0100, 16'h0000, 8'd1,  32'd0},
        '{8'h23, 9'h000, 16'h0000, 16'h2000, 8'd3,  32'd6},
        '{8'h15, 9'h1FF, 16'hFFFF, 16'hFFFF, 8'd6,  32'd0},
        '{8'h24, 9'h1FF, 16'hFFFF, 16'hFFFF, 8'd5,  32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  state_flags = '0;
    logic [15:0] pl_tx_bytes = '0;
    logic [15:0] pl_rx_bytes = '0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_activity_meter u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .state_flags (state_flags),
        .pl_tx_bytes (pl_tx_bytes),
        .pl_rx_bytes (pl_rx_bytes)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write is captured at the next posedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input logic [7:0] code, input logic [3:0] dur, input logic en);
        return {code, 12'h000, dur, 7'h00, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, lo1, lo2, hi;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h8, v); check("R1 hi", v, 32'h0);
        rd(4'h4, v); check("R1 lo", v, 32'h0);

        // R2 R3 R4 R5 R6 R8: vector table, each window auto-cleared
        for (int i = 0; i < NV; i++) begin
            state_flags = TBL[i].flags;
            pl_tx_bytes = TBL[i].txb;
            pl_rx_bytes = TBL[i].rxb;
            wr(4'h0, cw(TBL[i].code, 4'h0, 1'b1));
            idle(int'(TBL[i].win));
            wr(4'h0, cw(TBL[i].code, 4'h0, 1'b0));
            rd(4'h8, hi);
            rd(4'h4, v);
            check($sformatf("R5 R6 vec%0d code=%02h hi", i, TBL[i].code), hi, 32'h0);
            check($sformatf("R2 R3 R4 R8 vec%0d code=%02h", i, TBL[i].code), v, TBL[i].expv);
        end

        // R9: code change in an open window is ignored
        state_flags = '0; pl_tx_bytes = '0; pl_rx_bytes = '0;
        wr(4'h0, cw(8'h00, 4'h0, 1'b1));
        idle(2);
        wr(4'h0, cw(8'h01, 4'h0, 1'b1));
        idle(2);
        wr(4'h0, cw(8'h01, 4'h0, 1'b0));
        rd(4'h4, v);
        check("R9 code change mid window", v, 32'd5);

        // R6: result holds after the window closes
        idle(4);
        rd(4'h4, v);
        check("R6 hold after stop", v, 32'd5);

        // R7 R11: non-manual duration blocks a start; readback masks bits
        wr(4'h0, 32'hFFFF_FFFF);
        idle(5);
        rd(4'h0, v);
        check("R11 ctrl readback", v, 32'hFF00_0F01);
        rd(4'h4, v);
        check("R7 non-manual no start", v, 32'd5);
        wr(4'h0, 32'h0);

        // R10: high read captures low; next low read returns the capture
        wr(4'h0, cw(8'h00, 4'h0, 1'b1));
        idle(3);
        rd(4'h8, hi);
        rd(4'h4, lo1);
        rd(4'h4, lo2);
        check("R10 hi word", hi, 32'h0);
        check("R10 snapshot vs live", lo2 - lo1, 32'd2);
        wr(4'h0, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule